// File: doc/BRIEF.md
# Parallel AC/DC Coefficient Quantizer

This block turns one 4x4 block of signed transform coefficients into quantized levels in a single pass, all sixteen lanes at once. A quantization parameter from 0 to 51 sets both the scaling factor and the right shift. A mode input picks one of two rules. The first is the per-position rule used for ordinary transform output. The second is the rule used for the block of Hadamard-transformed DC terms.

Every lane takes the magnitude of its coefficient and multiplies it by a factor. It then adds a rounding offset, shifts right, and restores the sign of the input. The lookups that depend on the parameter are held in registers that load on start. The block is a three-stage pipeline, so it accepts a new block on every cycle and marks each finished block with a one-cycle done pulse.

Top module: `qz_core`

## Requirements
- R1: In AC mode (dc_mode_i = 0), the level of lane k is (|c|*MF + f) >> qb, with qb = 15 + floor(QP/6). The lane's position is row = k/4, column = k%4, with lane k taken from bits [16k+15:16k] of coef_i and placed in the same bits of level_o.
- R2: MF is chosen by position class and by QP%6 = 0..5. When row and column are both even, MF is 13107, 11916, 10082, 9362, 8192, 7282. When both are odd, MF is 5243, 4660, 4194, 3647, 3355, 2893. For every other position, MF is 8066, 7490, 6554, 5825, 5243, 4559.
- R3: The rounding offset f equals floor(2^qb / 3).
- R4: In DC mode (dc_mode_i = 1), every lane uses the even/even MF, the offset is 2f, and the shift is qb+1.
- R5: A level takes the sign of its input coefficient. A result of zero magnitude is output as 0, and an all-zero block gives all-zero levels.
- R6: done_o is high for exactly one cycle, after the third rising clock edge counted from (and including) the edge that samples start_i high. The levels of that block are valid in the same cycle.
- R7: Starts on consecutive cycles give results on consecutive cycles, in the order they were issued, each with its own QP and mode.
- R8: While rst_i is high and after it is released, done_o is 0 and every level is 0 until the first result.
- R9: Levels hold their last value while no new result completes, whatever happens on coef_i, qp_i and dc_mode_i.
- R10: The full input range is handled: -32768 at QP 0 in the even/even position gives -13107.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Samples coef_i, qp_i and dc_mode_i on this edge |
| dc_mode_i | input | 1 | 1 selects the DC rule, 0 selects the AC rule |
| qp_i | input | 6 | Quantization parameter, 0 to 51 |
| coef_i | input | 256 | Sixteen signed 16-bit coefficients; lane k at bits [16k+15:16k] |
| level_o | output | 256 | Sixteen signed 16-bit levels, same lane layout |
| done_o | output | 1 | One-cycle pulse when level_o carries a new block |

## Verification
Each block's levels and its done pulse appear together, three rising edges after the edge that samples start. The bench drives inputs on the falling edge and reads results on the falling edge that follows the third rising edge. One check confirms that done is still low one edge early and low again one edge later. Three back-to-back starts are read on three consecutive falling edges. Hold behaviour is read several cycles after the pulse, while the inputs are being changed.

// File: rtl/qz_pkg.sv
package qz_pkg;
   typedef enum logic [1:0] {
      CLS_EVEN = 2'd0,
      CLS_ODD  = 2'd1,
      CLS_MIX  = 2'd2
   } pos_class_e;

   function automatic pos_class_e class_of(input int lane, input int blk);
      int r;
      int c;
      r = lane / blk;
      c = lane % blk;
      if ((r % 2 == 0) && (c % 2 == 0)) return CLS_EVEN;
      if ((r % 2 == 1) && (c % 2 == 1)) return CLS_ODD;
      return CLS_MIX;
   endfunction

   function automatic logic [13:0] mf_of(input pos_class_e cls, input logic [2:0] rem);
      logic [13:0] v;
      unique case (cls)
         CLS_EVEN: case (rem)
            3'd0: v = 14'd13107; 3'd1: v = 14'd11916; 3'd2: v = 14'd10082;
            3'd3: v = 14'd9362;  3'd4: v = 14'd8192;  default: v = 14'd7282;
         endcase
         CLS_ODD: case (rem)
            3'd0: v = 14'd5243; 3'd1: v = 14'd4660; 3'd2: v = 14'd4194;
            3'd3: v = 14'd3647; 3'd4: v = 14'd3355; default: v = 14'd2893;
         endcase
         default: case (rem)
            3'd0: v = 14'd8066; 3'd1: v = 14'd7490; 3'd2: v = 14'd6554;
            3'd3: v = 14'd5825; 3'd4: v = 14'd5243; default: v = 14'd4559;
         endcase
      endcase
      return v;
   endfunction
endpackage

// File: rtl/qz_qp_rom.sv
module qz_qp_rom #(
   parameter int QP_W  = 6,
   parameter int MF_W  = 14,
   parameter int SH_W  = 5,
   parameter int ACC_W = 31
) (
   input  logic             clk,
   input  logic             rst_i,
   input  logic             ld_i,
   input  logic [QP_W-1:0]  qp_i,
   input  logic             dc_i,
   output logic [MF_W-1:0]  mf_even_o,
   output logic [MF_W-1:0]  mf_odd_o,
   output logic [MF_W-1:0]  mf_mix_o,
   output logic [ACC_W-1:0] off_o,
   output logic [SH_W-1:0]  sh_o,
   output logic             dc_o
);
   import qz_pkg::*;

   logic [2:0]       rem;
   logic [SH_W-1:0]  qb;
   logic [ACC_W-1:0] f;

   always_comb begin
      rem = 3'(qp_i % QP_W'(6));
      qb  = SH_W'(15) + SH_W'(qp_i / QP_W'(6));
      f   = (ACC_W'(1) << qb) / ACC_W'(3);
   end

   always_ff @(posedge clk) begin
      if (rst_i) begin
         mf_even_o <= '0;
         mf_odd_o  <= '0;
         mf_mix_o  <= '0;
         off_o     <= '0;
         sh_o      <= '0;
         dc_o      <= 1'b0;
      end else if (ld_i) begin
         mf_even_o <= MF_W'(mf_of(CLS_EVEN, rem));
         mf_odd_o  <= MF_W'(mf_of(CLS_ODD, rem));
         mf_mix_o  <= MF_W'(mf_of(CLS_MIX, rem));
         off_o     <= dc_i ? (f << 1) : f;
         sh_o      <= dc_i ? qb + SH_W'(1) : qb;
         dc_o      <= dc_i;
      end
   end

   AST_SHIFT_RANGE: assert property (@(posedge clk) disable iff (rst_i)
      ($past(ld_i) && ($past(qp_i) <= QP_W'(51))) |-> ((sh_o >= SH_W'(15)) && (sh_o <= SH_W'(24)))) // R1
      else $error("shift out of range");

   AST_DC_OFFSET_EVEN: assert property (@(posedge clk) disable iff (rst_i)
      ($past(ld_i) && $past(dc_i)) |-> (off_o[0] == 1'b0 && sh_o >= SH_W'(16))) // R4
      else $error("dc offset or shift wrong");
endmodule

// File: rtl/qz_lane.sv
module qz_lane #(
   parameter int          COEF_W = 16,
   parameter int          MF_W   = 14,
   parameter int          SH_W   = 5,
   parameter int          ACC_W  = 31,
   parameter int          OUT_W  = 16,
   parameter logic [1:0]  CLS    = 2'd0
) (
   input  logic                     clk,
   input  logic                     rst_i,
   input  logic                     ld1_i,
   input  logic                     ld2_i,
   input  logic                     ld3_i,
   input  logic signed [COEF_W-1:0] coef_i,
   input  logic [MF_W-1:0]          mf_even_i,
   input  logic [MF_W-1:0]          mf_odd_i,
   input  logic [MF_W-1:0]          mf_mix_i,
   input  logic [ACC_W-1:0]         off_i,
   input  logic [SH_W-1:0]          sh_i,
   input  logic                     dc_i,
   output logic signed [OUT_W-1:0]  lvl_o
);
   logic signed [COEF_W-1:0] c_q;
   logic [COEF_W-1:0]        mag;
   logic [MF_W-1:0]          mf_pos;
   logic [MF_W-1:0]          mf_use;
   logic [ACC_W-1:0]         sum_q;
   logic [SH_W-1:0]          sh_q;
   logic                     neg_q;
   logic [ACC_W-1:0]         shifted;

   generate
      if (CLS == 2'd0) begin : g_even
         assign mf_pos = mf_even_i;
      end else if (CLS == 2'd1) begin : g_odd
         assign mf_pos = mf_odd_i;
      end else begin : g_mix
         assign mf_pos = mf_mix_i;
      end
   endgenerate

   always_comb begin
      mag     = c_q[COEF_W-1] ? (~c_q + COEF_W'(1)) : c_q;
      mf_use  = dc_i ? mf_even_i : mf_pos;
      shifted = sum_q >> sh_q;
   end

   always_ff @(posedge clk) begin
      if (rst_i) begin
         c_q   <= '0;
         sum_q <= '0;
         sh_q  <= '0;
         neg_q <= 1'b0;
         lvl_o <= '0;
      end else begin
         if (ld1_i) c_q <= coef_i;
         if (ld2_i) begin
            sum_q <= ACC_W'(mag) * ACC_W'(mf_use) + off_i;
            sh_q  <= sh_i;
            neg_q <= c_q[COEF_W-1];
         end
         if (ld3_i) begin
            if (shifted == '0) lvl_o <= '0;
            else if (neg_q)    lvl_o <= -OUT_W'(shifted);
            else               lvl_o <= OUT_W'(shifted);
         end
      end
   end

   AST_ZERO_KEEPS_ZERO: assert property (@(posedge clk) disable iff (rst_i)
      ld3_i |=> (($past(c_q, 2) != '0) || (lvl_o == '0))) // R5
      else $error("zero input gave non-zero level");

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst_i)
      ld3_i |=> (lvl_o != {1'b1, {(OUT_W-1){1'b0}}})) // R1
      else $error("level overflow");
endmodule

// File: rtl/qz_core.sv
module qz_core #(
   parameter int BLK    = 4,
   parameter int COEF_W = 16,
   parameter int QP_W   = 6,
   parameter int MF_W   = 14,
   parameter int OUT_W  = 16
) (
   input  logic                           clk,
   input  logic                           rst_i,
   input  logic                           start_i,
   input  logic                           dc_mode_i,
   input  logic [QP_W-1:0]                qp_i,
   input  logic [BLK*BLK*COEF_W-1:0]      coef_i,
   output logic [BLK*BLK*OUT_W-1:0]       level_o,
   output logic                           done_o
);
   import qz_pkg::*;

   localparam int LANES = BLK * BLK;
   localparam int SH_W  = 5;
   localparam int ACC_W = COEF_W + MF_W + 1;

   generate
      if (BLK != 4) begin : g_bad_blk
         $error("qz_core: BLK must be 4");
      end
      if (MF_W < 14) begin : g_bad_mf
         $error("qz_core: MF_W must hold 13107");
      end
      if (OUT_W < COEF_W) begin : g_bad_out
         $error("qz_core: OUT_W narrower than COEF_W");
      end
      if (QP_W < 6) begin : g_bad_qp
         $error("qz_core: QP_W must cover 0..51");
      end
   endgenerate

   logic             v1, v2, v3;
   logic [MF_W-1:0]  mf_even, mf_odd, mf_mix;
   logic [ACC_W-1:0] off;
   logic [SH_W-1:0]  sh;
   logic             dc_q;

   always_ff @(posedge clk) begin
      if (rst_i) begin
         v1 <= 1'b0;
         v2 <= 1'b0;
         v3 <= 1'b0;
      end else begin
         v1 <= start_i;
         v2 <= v1;
         v3 <= v2;
      end
   end

   assign done_o = v3;

   qz_qp_rom #(.QP_W(QP_W), .MF_W(MF_W), .SH_W(SH_W), .ACC_W(ACC_W)) u_rom (
      .clk       (clk),
      .rst_i     (rst_i),
      .ld_i      (start_i),
      .qp_i      (qp_i),
      .dc_i      (dc_mode_i),
      .mf_even_o (mf_even),
      .mf_odd_o  (mf_odd),
      .mf_mix_o  (mf_mix),
      .off_o     (off),
      .sh_o      (sh),
      .dc_o      (dc_q)
   );

   generate
      for (genvar k = 0; k < LANES; k++) begin : g_lane
         localparam logic [1:0] CLS_K = 2'(class_of(k, BLK));
         logic signed [OUT_W-1:0] lvl;
         qz_lane #(
            .COEF_W(COEF_W), .MF_W(MF_W), .SH_W(SH_W),
            .ACC_W(ACC_W), .OUT_W(OUT_W), .CLS(CLS_K)
         ) u_lane (
            .clk       (clk),
            .rst_i     (rst_i),
            .ld1_i     (start_i),
            .ld2_i     (v1),
            .ld3_i     (v2),
            .coef_i    (coef_i[k*COEF_W +: COEF_W]),
            .mf_even_i (mf_even),
            .mf_odd_i  (mf_odd),
            .mf_mix_i  (mf_mix),
            .off_i     (off),
            .sh_i      (sh),
            .dc_i      (dc_q),
            .lvl_o     (lvl)
         );
         assign level_o[k*OUT_W +: OUT_W] = lvl;
      end
   endgenerate

   AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (rst_i)
      start_i |=> ##2 done_o) // R6
      else $error("done missing after start");

   AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (rst_i)
      done_o |-> $past(start_i, 3)) // R6
      else $error("done without start");

   AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (rst_i)
      !$past(v2) |-> $stable(level_o)) // R9
      else $error("levels changed without result");
endmodule

// File: tb/tb_qz_core.sv
module tb_qz_core;
   localparam int LANES = 16;

   logic         clk = 1'b0;
   logic         rst_i;
   logic         start_i;
   logic         dc_mode_i;
   logic [5:0]   qp_i;
   logic [255:0] coef_i;
   logic [255:0] level_o;
   logic         done_o;

   int n_checks = 0;
   int n_errors = 0;
   int cycles   = 0;

   always #10 clk = ~clk;

   qz_core dut (
      .clk(clk), .rst_i(rst_i), .start_i(start_i), .dc_mode_i(dc_mode_i),
      .qp_i(qp_i), .coef_i(coef_i), .level_o(level_o), .done_o(done_o)
   );

   // {dc(8), qp(8), base(16), step(16)}
   localparam logic [47:0] VEC [8] = '{
      {8'd0,  8'd0, 16'sd100,    16'sd37},
      {8'd0, 8'd28, -16'sd500,   16'sd90},
      {8'd0, 8'd51, 16'sd32767, -16'sd2000},
      {8'd0, 8'd17, -16'sd32768, 16'sd1500},
      {8'd1,  8'd0, 16'sd1000,  -16'sd150},
      {8'd1, 8'd33, -16'sd20000, 16'sd2500},
      {8'd1, 8'd51, 16'sd32767, -16'sd4000},
      {8'd0,  8'd6, 16'sd3,     -16'sd1}
   };

   function automatic int mf_ref(int k, int rem);
      int r = k / 4;
      int c = k % 4;
      int t [3][6] = '{'{13107, 11916, 10082, 9362, 8192, 7282},
                       '{5243, 4660, 4194, 3647, 3355, 2893},
                       '{8066, 7490, 6554, 5825, 5243, 4559}};
      if (r % 2 == 0 && c % 2 == 0) return t[0][rem];
      if (r % 2 == 1 && c % 2 == 1) return t[1][rem];
      return t[2][rem];
   endfunction

   function automatic int exp_level(bit dc, int qp, int k, int c);
      int qb = 15 + qp / 6;
      longint mag = (c < 0) ? -longint'(c) : longint'(c);
      longint f = (longint'(1) << qb) / 3;
      longint mf = dc ? mf_ref(0, qp % 6) : mf_ref(k, qp % 6);
      longint s = mag * mf + (dc ? 2 * f : f);
      longint l = s >> (dc ? qb + 1 : qb);
      return (c < 0) ? -int'(l) : int'(l);
   endfunction

   function automatic int lane_out(int k);
      logic signed [15:0] v = level_o[k*16 +: 16];
      return int'(v);
   endfunction

   task automatic chk(string req, int act, int exp);
      n_checks++;
      if (act != exp) begin
         n_errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic chk_block(string req, bit dc, int qp, int cf [LANES]);
      int bad = 0;
      n_checks++;
      for (int k = 0; k < LANES; k++) begin
         int e = exp_level(dc, qp, k, cf[k]);
         if (lane_out(k) != e) begin
            bad++;
            $display("FAIL %s lane %0d: actual=%0d expected=%0d", req, k, lane_out(k), e);
         end
      end
      if (bad != 0) n_errors++;
   endtask

   task automatic drive(bit dc, int qp, int cf [LANES]);
      start_i   = 1'b1;
      dc_mode_i = dc;
      qp_i      = 6'(qp);
      for (int k = 0; k < LANES; k++) coef_i[k*16 +: 16] = 16'(cf[k]);
   endtask

   task automatic run_one(string req, bit dc, int qp, int cf [LANES]);
      @(negedge clk);
      drive(dc, qp, cf);
      @(posedge clk);
      @(negedge clk);
      start_i = 1'b0;
      @(posedge clk);
      @(posedge clk);
      @(negedge clk);
      chk({req, " done"}, int'(done_o), 1);
      chk_block(req, dc, qp, cf);
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 50000) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=%0d expected<50000", cycles);
            finish_run();
         end
      end
   end

   initial begin
      int cf [LANES];
      int ca [LANES];
      int cb [LANES];
      int cc [LANES];
      logic [255:0] snap;
      rst_i = 1'b1; start_i = 1'b0; dc_mode_i = 1'b0; qp_i = '0; coef_i = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R8: reset state
      chk("R8 done in reset", int'(done_o), 0);
      chk("R8 levels in reset", int'(level_o == '0), 1);
      rst_i = 1'b0;
      @(negedge clk);
      chk("R8 done after reset", int'(done_o), 0);
      chk("R8 levels after reset", int'(level_o == '0), 1);

      // R1 R2 R3 R4 R5: vector table
      for (int v = 0; v < 8; v++) begin
         bit dc = VEC[v][40];
         int qp = int'(VEC[v][39:32]);
         int base = int'($signed(VEC[v][31:16]));
         int step = int'($signed(VEC[v][15:0]));
         for (int k = 0; k < LANES; k++) cf[k] = base + k * step;
         run_one(dc ? "R4 dc vector" : "R1 R2 R3 ac vector", dc, qp, cf);
      end

      // R5: all-zero block, and sign on mixed signs
      for (int k = 0; k < LANES; k++) cf[k] = 0;
      run_one("R5 zero block", 1'b0, 20, cf);
      chk("R5 zero levels", int'(level_o == '0), 1);
      for (int k = 0; k < LANES; k++) cf[k] = (k % 2 == 0) ? -(k * 700 + 40) : (k * 700 + 40);
      run_one("R5 signs", 1'b0, 12, cf);
      chk("R5 negative lane0", int'(lane_out(0) < 0), 1);

      // R10: most negative input
      for (int k = 0; k < LANES; k++) cf[k] = -32768;
      run_one("R10 min input", 1'b0, 0, cf);
      chk("R10 lane0", lane_out(0), -13107);

      // R6: done timing
      for (int k = 0; k < LANES; k++) cf[k] = 50 * k;
      @(negedge clk);
      drive(1'b0, 10, cf);
      @(posedge clk);
      @(negedge clk);
      start_i = 1'b0;
      @(posedge clk);
      @(negedge clk);
      chk("R6 done early", int'(done_o), 0);
      @(posedge clk);
      @(negedge clk);
      chk("R6 done on time", int'(done_o), 1);
      @(posedge clk);
      @(negedge clk);
      chk("R6 done one cycle", int'(done_o), 0);

      // R9: hold while inputs change
      snap = level_o;
      qp_i = 6'd40; dc_mode_i = 1'b1; coef_i = {16{16'h1234}};
      repeat (4) @(negedge clk);
      chk("R9 hold", int'(level_o == snap), 1);

      // R7: back-to-back starts
      for (int k = 0; k < LANES; k++) begin
         ca[k] = 1000 + 300 * k;
         cb[k] = -(2000 + 111 * k);
         cc[k] = 7000 - 900 * k;
      end
      @(negedge clk); drive(1'b0, 3, ca);
      @(negedge clk); drive(1'b1, 45, cb);
      @(negedge clk); drive(1'b0, 30, cc);
      @(negedge clk); start_i = 1'b0;
      chk("R7 first done", int'(done_o), 1);
      chk_block("R7 first", 1'b0, 3, ca);
      @(negedge clk);
      chk("R7 second done", int'(done_o), 1);
      chk_block("R7 second", 1'b1, 45, cb);
      @(negedge clk);
      chk("R7 third done", int'(done_o), 1);
      chk_block("R7 third", 1'b0, 30, cc);
      @(negedge clk);
      chk("R7 done drops", int'(done_o), 0);

      finish_run();
   end
endmodule